// File: doc/BRIEF.md
# Capture/Compare Timer with Clock Prescaler

This block is a 16-bit up-counter that advances on a divided version of its clock. The divide ratio is a power of two, from 1 to 128, chosen by a 3-bit field. Eight channels share the counter. Each channel is set up either to record the counter value when a rising edge arrives on its input pin, or to signal when the counter reaches a stored value.

Every channel has an event flag, and the counter has an overflow flag. Software clears a flag by writing a one to its bit. Each flag has a mask bit that routes it to an interrupt output. An optional mode uses channel 7 as a period register: a channel 7 match sends the counter back to zero instead of letting it increment.

Software reaches the block through a synchronous register port. The port has an address, write data, a write strobe and a registered read-data output.

Top module: `capture_compare_timer`

## Requirements
- R1: The counter advances by one once every 2^P clock cycles while running, where P is CTRL bits [3:1] (CTRL at address 0). Over any window of K cycles, with K a multiple of 2^P, it advances by exactly K/2^P.
- R2: While CTRL bit 0 (run) is clear, neither the counter nor the prescaler changes.
- R3: A tick taken while the counter holds 0xFFFF returns the counter to 0x0000 and sets FLAGS bit 8 (FLAGS at address 3).
- R4: A channel n whose MODE bit n is 0 (MODE at address 1) detects rising edges on cap_in[n] through a two-stage synchronizer. On the third rising clock edge after the pin is first sampled high, the channel copies the counter value held before that edge into CHn (address 8+n) and sets FLAGS bit n. A pin that stays high does not capture again.
- R5: A channel n whose MODE bit n is 1 sets FLAGS bit n on the tick at which the counter equals CHn.
- R6: When CTRL bit 5 is set and channel 7 matches in compare mode, the counter goes to 0 on that tick instead of incrementing.
- R7: Writing FLAGS clears each flag whose write-data bit is 1. Flags written with 0 keep their value.
- R8: When a new event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R9: irq_chan[n] is FLAGS bit n AND IEN bit n (IEN at address 2). irq_ovf is FLAGS bit 8 AND CTRL bit 4.
- R10: reg_rdata shows, one cycle after the address is presented, the register at that address: 0 CTRL, 1 MODE, 2 IEN, 3 FLAGS, 4 COUNT, 8 to 15 CH0 to CH7. Every other address reads 0. Writes to COUNT are ignored. All registers and reg_rdata reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Registered read data |
| cap_in | input | 8 | Asynchronous capture pins, one per channel |
| irq_chan | output | 8 | Masked channel event interrupts |
| irq_ovf | output | 1 | Masked overflow interrupt |

## Verification
Each result has a fixed latency after its stimulus:
- Read data appears one edge after the address is presented.
- A write to a control or flag register takes effect at the edge that samples it.
- A compare flag and its interrupt appear just after the edge on which the matching count was ticked.
- A capture flag, its interrupt and the latched value appear three edges after the pin goes high.

The reference model in the bench advances at the same edges from the same pre-edge state. Its registers, flags and interrupt outputs are compared with the design at every falling edge, so each result is checked in the exact cycle it is due. The collision case is timed from the model's own synchronizer state, so the clearing write lands in the same cycle as the capture event.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W    = 16;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int NUM_CH   = 8;
  localparam int PSEL_W   = 3;
  localparam int PRE_W    = (1 << PSEL_W) - 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd4;

  typedef struct packed {
    logic              rst_on_cmp;
    logic              ovf_ie;
    logic [PSEL_W-1:0] psel;
    logic              run;
  } ctrl_t;

  // true on the last prescaler state of each 2^sel period
  function automatic logic prescale_due(input logic [PRE_W-1:0] pre,
                                        input logic [PSEL_W-1:0] sel);
    logic [PRE_W-1:0] mask;
    mask = PRE_W'((1 << sel) - 1);
    return (pre & mask) == mask;
  endfunction

  // address of channel register n
  function automatic logic [ADDR_W-1:0] chan_addr(input int n);
    return ADDR_W'(8 + n);
  endfunction
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler
  import cct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  assign tick = run && prescale_due(pre_q, psel);

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pre_q)); // R2
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_hit,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick)    cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign ovf_evt = tick && (cnt_q == CNT_MAX);

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt_q == '0); // R3
  AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_hit) |=> cnt_q == '0); // R6
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             is_cmp,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_val,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr,
  output logic [CNT_W-1:0] val,
  output logic             flag,
  output logic             evt,
  output logic             cmp_evt
);
  logic s1_q, s2_q, s3_q;
  logic cap_evt;
  logic [CNT_W-1:0] val_q;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else begin
      s1_q <= pin; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  assign cap_evt = !is_cmp && s2_q && !s3_q;
  assign cmp_evt = is_cmp && tick && (cnt == val_q);
  assign evt     = cap_evt || cmp_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)       val_q <= '0;
    else if (cap_evt) val_q <= cnt;
    else if (wr_val)  val_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= evt || (flag_q && !clr);
  end

  assign val  = val_q;
  assign flag = flag_q;

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q); // R8
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt && flag_q) |=> !flag_q); // R7
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> val_q == $past(cnt)); // R4
  AST_CMP_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmp && tick && cnt == val_q) |=> flag_q); // R5
endmodule

// File: rtl/capture_compare_timer.sv
module capture_compare_timer
  import cct_pkg::*;
#(
  parameter int N_CH = NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]   cap_in,
  output logic [N_CH-1:0]   irq_chan,
  output logic              irq_ovf
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [N_CH-1:0]  mode_q;
  logic [N_CH-1:0]  ien_q;
  logic             ovf_flag_q;
  logic [DATA_W-1:0] rdata_q;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             ovf_evt;
  logic             rst_hit;
  logic             flags_wr;
  logic [N_CH-1:0]  ch_flag, ch_evt, ch_cmp;
  logic [CNT_W-1:0] ch_val [N_CH];

  assign flags_wr = reg_we && (reg_addr == A_FLAGS);
  assign rst_hit  = ctrl_q.rst_on_cmp && ch_cmp[N_CH-1];

  cct_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .psel(ctrl_q.psel), .tick(tick)
  );

  cct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr_hit(rst_hit),
    .cnt(cnt), .ovf_evt(ovf_evt)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    cct_channel u_ch (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[n]), .is_cmp(mode_q[n]),
      .tick(tick), .cnt(cnt),
      .wr_val(reg_we && (reg_addr == chan_addr(n))),
      .wdata(reg_wdata[CNT_W-1:0]),
      .clr(flags_wr && reg_wdata[n]),
      .val(ch_val[n]), .flag(ch_flag[n]), .evt(ch_evt[n]), .cmp_evt(ch_cmp[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ien_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:  ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        A_MODE:  mode_q <= reg_wdata[N_CH-1:0];
        A_IEN:   ien_q  <= reg_wdata[N_CH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag_q <= 1'b0;
    else        ovf_flag_q <= ovf_evt || (ovf_flag_q && !(flags_wr && reg_wdata[N_CH]));
  end

  function automatic logic [DATA_W-1:0] read_mux(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] r;
    r = '0;
    case (a)
      A_CTRL:  r = DATA_W'(ctrl_q);
      A_MODE:  r = DATA_W'(mode_q);
      A_IEN:   r = DATA_W'(ien_q);
      A_FLAGS: r = DATA_W'({ovf_flag_q, ch_flag});
      A_COUNT: r = DATA_W'(cnt);
      default: begin
        for (int n = 0; n < N_CH; n++)
          if (a == chan_addr(n)) r = DATA_W'(ch_val[n]);
      end
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= read_mux(reg_addr);
  end

  assign reg_rdata = rdata_q;
  assign irq_chan  = ch_flag & ien_q;
  assign irq_ovf   = ovf_flag_q && ctrl_q.ovf_ie;

  AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag_q); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > A_COUNT && reg_addr < 4'd8) |=> reg_rdata == '0); // R10
  AST_COUNT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_COUNT) |=> reg_rdata == DATA_W'($past(cnt))); // R10
  AST_IRQ_OVF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovf) |-> ctrl_q.ovf_ie); // R9
endmodule

// File: tb/test_capture_compare_timer.sv
module test_capture_compare_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic [7:0]  cap_in = '0;
  logic [7:0]  irq_chan;
  logic        irq_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_compare_timer i_capture_compare_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .irq_chan(irq_chan), .irq_ovf(irq_ovf)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string tag = "R10";

  // ---------------- behavioural reference model ----------------
  bit m_run, m_oie, m_rste;
  int m_psel, m_pre, m_cnt, m_rd;
  bit m_mode[8], m_ien[8], m_flag[9], m_s1[8], m_s2[8], m_s3[8];
  int m_val[8];

  function automatic int model_read(int a);
    int r = 0;
    if (a == 0) r = (int'(m_rste) << 5) | (int'(m_oie) << 4) | (m_psel << 1) | int'(m_run);
    else if (a == 1) begin for (int i = 0; i < 8; i++) if (m_mode[i]) r |= (1 << i); end
    else if (a == 2) begin for (int i = 0; i < 8; i++) if (m_ien[i]) r |= (1 << i); end
    else if (a == 3) begin for (int i = 0; i < 9; i++) if (m_flag[i]) r |= (1 << i); end
    else if (a == 4) r = m_cnt;
    else if (a >= 8) r = m_val[a-8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_oie = 0; m_rste = 0; m_psel = 0; m_pre = 0; m_cnt = 0; m_rd = 0;
      for (int i = 0; i < 8; i++) begin
        m_mode[i] = 0; m_ien[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_val[i] = 0;
      end
      for (int i = 0; i < 9; i++) m_flag[i] = 0;
    end else begin
      bit tick, ovf, hit7;
      bit e_cmp[8], e_cap[8];
      int rd, a;
      a = int'(reg_addr);
      tick = m_run && ((m_pre % (1 << m_psel)) == (1 << m_psel) - 1);
      rd = model_read(a);
      for (int i = 0; i < 8; i++) begin
        e_cmp[i] = m_mode[i] && tick && (m_cnt == m_val[i]);
        e_cap[i] = !m_mode[i] && m_s2[i] && !m_s3[i];
      end
      ovf  = tick && (m_cnt == 65535);
      hit7 = m_rste && e_cmp[7];
      if (m_run) m_pre = (m_pre + 1) % 128;
      if (tick) m_cnt = hit7 ? 0 : (m_cnt + 1) % 65536;
      for (int i = 0; i < 8; i++) begin
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = cap_in[i];
      end
      if (reg_we) begin
        if (a == 0) begin
          m_run = reg_wdata[0]; m_psel = int'(reg_wdata[3:1]);
          m_oie = reg_wdata[4]; m_rste = reg_wdata[5];
        end
        if (a == 1) for (int i = 0; i < 8; i++) m_mode[i] = reg_wdata[i];
        if (a == 2) for (int i = 0; i < 8; i++) m_ien[i] = reg_wdata[i];
        if (a >= 8) m_val[a-8] = int'(reg_wdata);
      end
      for (int i = 0; i < 9; i++)
        if (reg_we && a == 3 && reg_wdata[i]) m_flag[i] = 0;
      for (int i = 0; i < 8; i++) begin
        if (e_cmp[i] || e_cap[i]) m_flag[i] = 1;
        if (e_cap[i]) m_val[i] = m_cnt_before(m_cnt, tick, hit7);
      end
      if (ovf) m_flag[8] = 1;
      m_rd = rd;
    end
  end

  // counter value before this edge, recovered from the updated value
  function automatic int m_cnt_before(int now, bit tick, bit hit7);
    if (!tick) return now;
    if (hit7) return m_val[7];
    return (now + 65535) % 65536;
  endfunction

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_irq;
      bit exp_ovf;
      for (int i = 0; i < 8; i++) exp_irq[i] = m_flag[i] && m_ien[i];
      exp_ovf = m_flag[8] && m_oie;
      n_chk++;
      if (reg_rdata !== 16'(m_rd) || irq_chan !== exp_irq || irq_ovf !== exp_ovf) begin
        n_err++;
        $display("FAIL %s cycle compare: rdata=%h irq=%h ovf=%b expected %h %h %b",
                 tag, reg_rdata, irq_chan, irq_ovf, 16'(m_rd), exp_irq, exp_ovf);
      end
    end
  end

  task automatic chk(input string t, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", t, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 4'(a); reg_wdata = 16'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 4'(a);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic r1_window(input int p, input int k);
    int v0, v1;
    wr(0, (p << 1) | 1);
    rd(4, v0);
    idle(k - 1);
    rd(4, v1);
    chk($sformatf("R1 prescale %0d delta", p), (v1 - v0 + 65536) % 65536, k >> p);
  endtask

  initial begin
    int v, v2;
    repeat (3) @(negedge clk);
    chk("R10 reset rdata", int'(reg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R10";
    for (int a = 0; a < 16; a++) begin rd(a, v); chk($sformatf("R10 reset reg %0d", a), v, 0); end
    wr(4, 16'h1234);
    rd(4, v); chk("R10 COUNT write ignored", v, 0);
    wr(6, 16'hFFFF);
    rd(6, v); chk("R10 unmapped reads zero", v, 0);

    tag = "R1";
    r1_window(0, 50);
    r1_window(3, 80);
    r1_window(7, 384);

    tag = "R2";
    wr(0, 0);
    rd(4, v); idle(40); rd(4, v2);
    chk("R2 stopped counter holds", v2, v);

    tag = "R5";
    rd(4, v);
    wr(1, 8'h0C);                      // channels 2,3 compare
    wr(2, 8'h04);
    wr(8 + 2, (v + 20) % 65536);
    wr(0, 1);
    idle(30);
    rd(3, v2);
    chk("R5 compare flag ch2", (v2 >> 2) & 1, 1);
    chk("R9 irq ch2 unmasked", int'(irq_chan[2]), 1);
    chk("R5 no flag ch3", (v2 >> 3) & 1, 0);

    tag = "R7";
    wr(3, 0);
    rd(3, v2); chk("R7 write zero keeps flag", (v2 >> 2) & 1, 1);
    wr(3, 8'h04);
    rd(3, v2); chk("R7 write one clears flag", (v2 >> 2) & 1, 0);
    chk("R9 irq ch2 after clear", int'(irq_chan[2]), 0);

    tag = "R4";
    cap_in[0] = 1'b1; idle(4); cap_in[0] = 1'b0; idle(4);
    rd(3, v2); chk("R4 capture flag ch0", v2 & 1, 1);
    chk("R9 irq ch0 masked", int'(irq_chan[0]), 0);
    rd(8, v); chk("R4 captured value", v, m_val[0]);
    wr(3, 1);
    cap_in[0] = 1'b1; idle(3);
    rd(3, v2); chk("R4 second capture flag", v2 & 1, 1);
    wr(3, 1); idle(10);
    rd(3, v2); chk("R4 steady high no recapture", v2 & 1, 0);
    cap_in[0] = 1'b0;

    tag = "R8";
    cap_in[1] = 1'b1; idle(4); cap_in[1] = 1'b0; idle(4);
    cap_in[1] = 1'b1;
    while (!(m_s2[1] && !m_s3[1])) @(negedge clk);
    wr(3, 8'h02);
    cap_in[1] = 1'b0;
    rd(3, v2); chk("R8 event beats clear", (v2 >> 1) & 1, 1);
    wr(3, 8'h02);
    rd(3, v2); chk("R7 clear without event", (v2 >> 1) & 1, 0);

    tag = "R3";
    wr(1, 0);
    wr(0, 16'h0011);                   // run, prescale 1, overflow irq on
    while (m_cnt < 65530) @(negedge clk);
    idle(10);
    rd(3, v2); chk("R3 overflow flag", (v2 >> 8) & 1, 1);
    chk("R9 irq_ovf enabled", int'(irq_ovf), 1);
    rd(4, v); chk("R3 counter wrapped small", int'(v < 20), 1);
    wr(0, 16'h0001);
    chk("R9 irq_ovf masked", int'(irq_ovf), 0);
    wr(3, 16'h0100);
    rd(3, v2); chk("R7 overflow flag cleared", (v2 >> 8) & 1, 0);

    tag = "R6";
    wr(0, 0);
    rd(4, v);
    wr(1, 8'h80);
    wr(8 + 7, v + 60);
    wr(0, 16'h0021);
    for (int i = 0; i < 6; i++) begin
      idle(37);
      rd(4, v2);
      chk("R6 counter bounded by ch7", int'(v2 <= v + 60), 1);
    end
    rd(3, v2); chk("R6 ch7 flag", (v2 >> 7) & 1, 1);

    tag = "R9";
    wr(2, 8'h80);
    chk("R9 irq ch7 enabled", int'(irq_chan[7]), 1);
    wr(2, 0);
    chk("R9 irq ch7 disabled", int'(irq_chan[7]), 0);
    idle(5);
    finish_run();
  end
endmodule